// File: doc/BRIEF.md
# Depth Expansion Token Controller

This block lets several FIFO instances be chained into one deeper buffer. Each instance holds a write token and a read token. Only the holder of a token may accept writes or reads. When the holder writes its final memory location, it hands the write token to the next device in the ring with a one-cycle pulse. The read token moves the same way when the final location is read. Storage, pointers and flag thresholds live outside this block. The block only receives the strobes and the "final location" indications and returns the permissions.

A chain-mode strap selects between ring operation and stand-alone use.
- **Ring operation:** a head strap, tied low on exactly one device of the ring, marks the device that owns both tokens after reset.
- **Stand-alone use (single device, or devices placed side by side for width):** the expansion inputs are tied low and the device always owns both tokens. The write-expansion output pin then reports the half-full state as an active-low level.

Top module: `xpand_token_ctrl`

## Requirements
- R1: In chain mode (`depth_mode`=1), a synchronous reset gives both tokens (`wr_ok`=1, `rd_ok`=1) to the device whose `head_n` is 0 and no token to a device whose `head_n` is 1. Both expansion outputs read 0 after reset.
- R2: In stand-alone mode (`depth_mode`=0), `wr_ok` and `rd_ok` stay 1 from reset onward, whatever is driven on `wr_xi`, `rd_xi`, the strobes and the last-location inputs.
- R3: In stand-alone mode, `wr_xo_hf` equals the inverse of `half_full` (0 when more than half full), and `rd_xo` stays 0 even when a last-location read is strobed.
- R4: In chain mode, when a write-token holder samples `wr_req`=1 and `wr_last`=1 at a clock edge:
  - `wr_xo_hf` is 1 for exactly the following cycle;
  - `wr_ok` is 0 from that same cycle on.
- R5: In chain mode, the same holds on the read side: a holder that samples `rd_req`=1 and `rd_last`=1 drives `rd_xo` to 1 for exactly one cycle and drops `rd_ok` in that cycle.
- R6: In chain mode, a device without a token that samples its expansion input at 1 at an edge holds that token (`wr_ok` or `rd_ok` = 1) from the next cycle on.
- R7: In chain mode, no expansion pulse is produced and no token is released unless the holder samples both request and last-location at 1. A non-holder's requests, and a holder's requests without last-location, leave the outputs unchanged.
- R8: In a ring of three devices, each of four locations deep:
  - at most one device accepts a write, and at most one a read, in any cycle;
  - each handoff costs exactly one cycle with no owner;
  - words come back in the order they were written across device boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| depth_mode | input | 1 | Strap: 1 = ring (depth) operation, 0 = stand-alone |
| head_n | input | 1 | Strap: 0 on the device that starts as owner |
| wr_xi | input | 1 | Write-token pulse from the previous device |
| rd_xi | input | 1 | Read-token pulse from the previous device |
| wr_req | input | 1 | Local write strobe |
| wr_last | input | 1 | The write at hand targets the final location |
| rd_req | input | 1 | Local read strobe |
| rd_last | input | 1 | The read at hand targets the final location |
| half_full | input | 1 | More-than-half-full level from the flag logic |
| wr_xo_hf | output | 1 | Write-token pulse (chain) or active-low half-full (stand-alone) |
| rd_xo | output | 1 | Read-token pulse to the next device |
| wr_ok | output | 1 | This device may accept writes |
| rd_ok | output | 1 | This device may accept reads |

## Verification
The ring sweep writes and then reads every burst length from 1 to 12 words. Across the sweep, handoffs fall at every position of the local pointers.
- A design that released its token one cycle late, or kept it through the pulse, would let two devices accept in the same cycle, or would return words out of order.
- A pulse wider than one cycle, or a missing idle cycle, would change the arithmetically predicted cycle count of each burst.

Directed cases cover further failure modes:
- A last-location strobe on a device without the token: a design that pulsed here would hand a second token into the ring.
- A holder left idle with last-location high: a design that released here would drop the token.
- In stand-alone mode, stray input pulses and the half-full level: a design that obeyed the pulses would block local traffic, or drive the pin with the wrong polarity.

// File: rtl/xpt_pkg.sv
// Shared definitions for the depth expansion token controller.
package xpt_pkg;
    typedef enum logic {
        XPT_SOLO  = 1'b0,
        XPT_CHAIN = 1'b1
    } xpt_mode_e;

    localparam int SIDE_WR = 0;
    localparam int SIDE_RD = 1;
    localparam int N_SIDE  = 2;
endpackage

// File: rtl/xpt_token_cell.sv
// One token holder (write or read side).
// Holds ownership, releases it on an accepted final-location access while
// emitting a registered one-cycle pulse, and takes it back on an input pulse.
// Assumes the incoming pulse is one cycle wide and synchronous to clk.
module xpt_token_cell
    import xpt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  xpt_mode_e mode,
    input  logic      head_n,
    input  logic      tok_in,
    input  logic      req,
    input  logic      last,
    output logic      own,
    output logic      pulse
);
    logic hand_off;

    // Release condition: the holder accepts the access to the final location.
    always_comb begin
        hand_off = (mode == XPT_CHAIN) && own && req && last;
    end

    // Ownership and pulse state, reset to the strap-selected owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own   <= (mode == XPT_SOLO) || !head_n;
            pulse <= 1'b0;
        end else begin
            pulse <= hand_off;
            if (mode == XPT_SOLO) begin
                own <= 1'b1;
            end else if (hand_off) begin
                own <= 1'b0;
            end else if (tok_in) begin
                own <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/xpt_pin_mux.sv
// Output pin selection.
// In chain mode the pins carry the token pulses. In stand-alone mode the
// write pin carries the active-low half-full level and the read pin idles low.
module xpt_pin_mux
    import xpt_pkg::*;
(
    input  xpt_mode_e mode,
    input  logic      wr_pulse,
    input  logic      rd_pulse,
    input  logic      half_full,
    output logic      wr_pin,
    output logic      rd_pin
);
    // Pick pulse or flag per mode.
    always_comb begin
        if (mode == XPT_CHAIN) begin
            wr_pin = wr_pulse;
            rd_pin = rd_pulse;
        end else begin
            wr_pin = !half_full;
            rd_pin = 1'b0;
        end
    end
endmodule

// File: rtl/xpand_token_ctrl.sv
// Depth expansion token controller (top).
// Instantiates one token cell per side and the output pin mux.
// Assumes the straps are static after reset and the chain is wired as a ring.
module xpand_token_ctrl
    import xpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic depth_mode,
    input  logic head_n,
    input  logic wr_xi,
    input  logic rd_xi,
    input  logic wr_req,
    input  logic wr_last,
    input  logic rd_req,
    input  logic rd_last,
    input  logic half_full,
    output logic wr_xo_hf,
    output logic rd_xo,
    output logic wr_ok,
    output logic rd_ok
);
    xpt_mode_e         mode;
    logic [N_SIDE-1:0] tok_in_v;
    logic [N_SIDE-1:0] req_v;
    logic [N_SIDE-1:0] last_v;
    logic [N_SIDE-1:0] own_v;
    logic [N_SIDE-1:0] pulse_v;

    // Gather the per-side inputs into vectors.
    always_comb begin
        mode              = xpt_mode_e'(depth_mode);
        tok_in_v[SIDE_WR] = wr_xi;
        tok_in_v[SIDE_RD] = rd_xi;
        req_v[SIDE_WR]    = wr_req;
        req_v[SIDE_RD]    = rd_req;
        last_v[SIDE_WR]   = wr_last;
        last_v[SIDE_RD]   = rd_last;
    end

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        xpt_token_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (mode),
            .head_n (head_n),
            .tok_in (tok_in_v[s]),
            .req    (req_v[s]),
            .last   (last_v[s]),
            .own    (own_v[s]),
            .pulse  (pulse_v[s])
        );
    end

    xpt_pin_mux u_mux (
        .mode      (mode),
        .wr_pulse  (pulse_v[SIDE_WR]),
        .rd_pulse  (pulse_v[SIDE_RD]),
        .half_full (half_full),
        .wr_pin    (wr_xo_hf),
        .rd_pin    (rd_xo)
    );

    // Permissions straight from ownership.
    always_comb begin
        wr_ok = own_v[SIDE_WR];
        rd_ok = own_v[SIDE_RD];
    end
endmodule

// File: rtl/xpand_token_chk.sv
// Property checker for xpand_token_ctrl, attached with bind.
module xpand_token_chk (
    input logic clk,
    input logic rst_n,
    input logic depth_mode,
    input logic wr_xi,
    input logic rd_xi,
    input logic wr_req,
    input logic wr_last,
    input logic rd_req,
    input logic rd_last,
    input logic wr_xo_hf,
    input logic rd_xo,
    input logic wr_ok,
    input logic rd_ok
);
    p_solo_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !depth_mode |=> (wr_ok && rd_ok) || depth_mode);

    p_wr_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        depth_mode && wr_ok && wr_req && wr_last |=> wr_xo_hf && !wr_ok);

    p_rd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        depth_mode && rd_ok && rd_req && rd_last |=> rd_xo && !rd_ok);

    p_wr_acquire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        depth_mode && wr_xi && !wr_ok |=> wr_ok);

    p_rd_acquire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        depth_mode && rd_xi && !rd_ok |=> rd_ok);

    p_wr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth_mode && !(wr_ok && wr_req && wr_last) |=> !wr_xo_hf || !depth_mode);

    p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ok && rd_req && rd_last) |=> !rd_xo);

    p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth_mode && wr_ok && !(wr_req && wr_last) |=> wr_ok);

    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        depth_mode && rd_ok && !(rd_req && rd_last) |=> rd_ok);
endmodule

bind xpand_token_ctrl xpand_token_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .depth_mode (depth_mode),
    .wr_xi      (wr_xi),
    .rd_xi      (rd_xi),
    .wr_req     (wr_req),
    .wr_last    (wr_last),
    .rd_req     (rd_req),
    .rd_last    (rd_last),
    .wr_xo_hf   (wr_xo_hf),
    .rd_xo      (rd_xo),
    .wr_ok      (wr_ok),
    .rd_ok      (rd_ok)
);

// File: tb/tb_xpand_token_ctrl.sv
module tb_xpand_token_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [2:0] wr_req, wr_last, rd_req, rd_last;
    wire  [2:0] wr_ok, rd_ok, wr_xo, rd_xo;

    logic s_wxi, s_rxi, s_req, s_last, s_hf;
    wire  s_wxo, s_rxo, s_wok, s_rok;

    int checks = 0;
    int errors = 0;
    int wptr[3];
    int rptr[3];
    int mem[3][4];
    int wseq, rseq;

    xpand_token_ctrl dut (
        .clk(clk), .rst_n(rst_n), .depth_mode(1'b1), .head_n(1'b0),
        .wr_xi(wr_xo[2]), .rd_xi(rd_xo[2]),
        .wr_req(wr_req[0]), .wr_last(wr_last[0]),
        .rd_req(rd_req[0]), .rd_last(rd_last[0]), .half_full(1'b0),
        .wr_xo_hf(wr_xo[0]), .rd_xo(rd_xo[0]), .wr_ok(wr_ok[0]), .rd_ok(rd_ok[0]));

    xpand_token_ctrl u_dev1 (
        .clk(clk), .rst_n(rst_n), .depth_mode(1'b1), .head_n(1'b1),
        .wr_xi(wr_xo[0]), .rd_xi(rd_xo[0]),
        .wr_req(wr_req[1]), .wr_last(wr_last[1]),
        .rd_req(rd_req[1]), .rd_last(rd_last[1]), .half_full(1'b0),
        .wr_xo_hf(wr_xo[1]), .rd_xo(rd_xo[1]), .wr_ok(wr_ok[1]), .rd_ok(rd_ok[1]));

    xpand_token_ctrl u_dev2 (
        .clk(clk), .rst_n(rst_n), .depth_mode(1'b1), .head_n(1'b1),
        .wr_xi(wr_xo[1]), .rd_xi(rd_xo[1]),
        .wr_req(wr_req[2]), .wr_last(wr_last[2]),
        .rd_req(rd_req[2]), .rd_last(rd_last[2]), .half_full(1'b0),
        .wr_xo_hf(wr_xo[2]), .rd_xo(rd_xo[2]), .wr_ok(wr_ok[2]), .rd_ok(rd_ok[2]));

    xpand_token_ctrl u_solo (
        .clk(clk), .rst_n(rst_n), .depth_mode(1'b0), .head_n(1'b1),
        .wr_xi(s_wxi), .rd_xi(s_rxi),
        .wr_req(s_req), .wr_last(s_last),
        .rd_req(s_req), .rd_last(s_last), .half_full(s_hf),
        .wr_xo_hf(s_wxo), .rd_xo(s_rxo), .wr_ok(s_wok), .rd_ok(s_rok));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_req = '0; wr_last = '0; rd_req = '0; rd_last = '0;
        s_wxi = 0; s_rxi = 0; s_req = 0; s_last = 0; s_hf = 0;
        for (int d = 0; d < 3; d++) begin
            wptr[d] = 0;
            rptr[d] = 0;
        end
        wseq = 0;
        rseq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One ring cycle: called at a negedge, models the storage, returns accept counts.
    task automatic step(input bit wen, input bit ren, output int nw, output int nr);
        nw = 0;
        nr = 0;
        for (int d = 0; d < 3; d++) begin
            wr_req[d]  = wen;
            wr_last[d] = (wptr[d] == 3);
            rd_req[d]  = ren;
            rd_last[d] = (rptr[d] == 3);
            if (wen && wr_ok[d]) begin
                mem[d][wptr[d]] = wseq;
                wseq++;
                wptr[d] = (wptr[d] + 1) % 4;
                nw++;
            end
            if (ren && rd_ok[d]) begin
                chk("R8 read order", mem[d][rptr[d]], rseq);
                rseq++;
                rptr[d] = (rptr[d] + 1) % 4;
                nr++;
            end
        end
        if (nw > 1 || nr > 1) begin
            checks++;
            errors++;
            $display("FAIL R8 single owner actual=%0d expected=1", (nw > nr) ? nw : nr);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nw, nr, cyc, exp_cyc, g0, got;
        do_reset();
        // R1 reset state of the ring
        chk("R1 head wr_ok", wr_ok[0], 1);
        chk("R1 head rd_ok", rd_ok[0], 1);
        chk("R1 others wr_ok", wr_ok[2:1], 0);
        chk("R1 others rd_ok", rd_ok[2:1], 0);
        chk("R1 xo idle", {wr_xo, rd_xo}, 0);

        // R7 / R4 / R5: last strobes on every device, only the head may pulse
        wr_req = 3'b111; wr_last = 3'b111; rd_req = 3'b111; rd_last = 3'b111;
        @(posedge clk); @(negedge clk);
        chk("R4 head wr pulse", wr_xo[0], 1);
        chk("R4 head wr_ok dropped", wr_ok[0], 0);
        chk("R5 head rd pulse", rd_xo[0], 1);
        chk("R5 head rd_ok dropped", rd_ok[0], 0);
        chk("R7 non-holders no wr pulse", wr_xo[2:1], 0);
        chk("R7 non-holders no rd pulse", rd_xo[2:1], 0);
        wr_req = '0; rd_req = '0;
        @(posedge clk); @(negedge clk);
        chk("R6 dev1 acquires wr", wr_ok[1], 1);
        chk("R6 dev1 acquires rd", rd_ok[1], 1);
        chk("R4 pulse one cycle", wr_xo[0], 0);
        chk("R5 pulse one cycle", rd_xo[0], 0);
        // R7 holder idle with last high keeps the token
        repeat (3) @(negedge clk);
        chk("R7 idle holder keeps wr", wr_ok, 3'b010);
        chk("R7 idle holder keeps rd", rd_ok, 3'b010);
        chk("R7 no pulse while idle", {wr_xo, rd_xo}, 0);

        // R8 ring sweep over every burst length
        do_reset();
        for (int n = 1; n <= 12; n++) begin
            g0 = wseq;
            exp_cyc = n;
            for (int i = g0; i <= g0 + n - 2; i++) if (i % 4 == 3) exp_cyc++;
            cyc = 0;
            got = 0;
            while (got < n && cyc < 100) begin
                step(1'b1, 1'b0, nw, nr);
                got += nw;
                cyc++;
            end
            chk("R8 write burst cycles", cyc, exp_cyc);
            step(1'b0, 1'b0, nw, nr);
            step(1'b0, 1'b0, nw, nr);
            cyc = 0;
            got = 0;
            while (got < n && cyc < 100) begin
                step(1'b0, 1'b1, nw, nr);
                got += nr;
                cyc++;
            end
            chk("R8 read burst cycles", cyc, exp_cyc);
            step(1'b0, 1'b0, nw, nr);
            step(1'b0, 1'b0, nw, nr);
        end
        chk("R8 all words read", rseq, 78);

        // R2 / R3 stand-alone device
        do_reset();
        chk("R2 solo wr_ok after reset", s_wok, 1);
        chk("R2 solo rd_ok after reset", s_rok, 1);
        s_wxi = 1; s_rxi = 1; s_req = 1; s_last = 1;
        @(posedge clk); @(negedge clk);
        s_wxi = 0; s_rxi = 0;
        @(posedge clk); @(negedge clk);
        chk("R2 solo wr_ok kept", s_wok, 1);
        chk("R2 solo rd_ok kept", s_rok, 1);
        chk("R3 solo rd pin low", s_rxo, 0);
        s_hf = 0; #1;
        chk("R3 half-full pin inactive", s_wxo, 1);
        s_hf = 1; #1;
        chk("R3 half-full pin active", s_wxo, 0);
        s_req = 0; s_last = 0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule